// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block is a hardware loop that turns one register-to-register operation, written in scalar form, into a stream of per-element operations on the ordinary 32-entry integer register file. A start pulse delivers the destination and the two source register numbers, a global vector length and the destination's own vector length. It also delivers one flag per operand saying whether that operand is a vector. The sequencer then considers one element per cycle. For each element it presents the three register indices to use and a write enable.

Masking uses a small key-value table. Each entry maps a referenced destination register to the integer register that holds its mask bits, and may ask for those bits to be complemented. When a start is presented, the block looks up the destination and drives the mask register number out. The register file's contents for that register come back on the same cycle and are captured. A masked-off element only has its write enable held low, so its destination keeps its previous value and nothing is zeroed. An operand that is not a vector keeps the same register for every element. A scalar operand and a vector operand therefore run on the same loop.

Top module: `vec_issue_seq`

## Requirements
- R1: The number of elements considered equals the smaller of the global length and the destination length, each first clamped to XLEN. One element is considered per cycle, with elemIdx counting 0,1,2,…, and busy is high for exactly that many cycles, starting the cycle after the accepted start.
- R2: The write enable for element i is high only when bit i of the effective mask is set. A masked element leaves elemWe low for its cycle, so the destination is not written or zeroed.
- R3: On element i, each of the destination, source-1 and source-2 indices equals its base register plus i when that operand's vector flag is 1. When the flag is 0 it equals the base register. All sums are taken modulo 32.
- R4: A table entry matches when it is valid, its register-file select bit is 0 (integer), and its 5-bit key equals the start's destination. On a match, predRegSel shows the entry's 5-bit value during the start cycle, and predData on that cycle is captured as the mask.
- R5: When the matching entry's invert bit is 1, the captured mask is the bitwise complement of predData.
- R6: When no entry matches, including when the only entry keyed to the destination has select bit 1 (floating point), every element is enabled.
- R7: When several entries match, the one in the lowest-numbered slot decides the mask.
- R8: done is high for exactly one cycle, the cycle after the last element. When the element count is zero, done rises the cycle after the start, busy stays low and no write enable is issued.
- R9: A start presented while busy or done is high is ignored. The running sequence continues unchanged, and after done the block returns to idle.
- R10: After reset, busy, done and elemWe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tblWe | input | 1 | Write strobe for one table slot |
| tblSlot | input | 2 | Slot number to write |
| tblValid | input | 1 | Valid bit written to the slot |
| tblFp | input | 1 | Register-file select written (0 integer, 1 floating point) |
| tblKey | input | 5 | Register being masked (key) |
| tblVal | input | 5 | Register holding the mask bits (value) |
| tblInv | input | 1 | Complement-mask bit |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| rdIn | input | 5 | Destination base register |
| rs1In | input | 5 | Source-1 base register |
| rs2In | input | 5 | Source-2 base register |
| rdVec | input | 1 | Destination is a vector |
| rs1Vec | input | 1 | Source 1 is a vector |
| rs2Vec | input | 1 | Source 2 is a vector |
| vlIn | input | 6 | Global vector length |
| rdLenIn | input | 6 | Destination vector length |
| predRegSel | output | 5 | Mask register number looked up from rdIn |
| predData | input | 32 | Contents of register predRegSel |
| busy | output | 1 | An element is being considered this cycle |
| done | output | 1 | One-cycle end-of-sequence pulse |
| elemWe | output | 1 | Issue and write the current element |
| elemIdx | output | 5 | Current element number |
| elemRd | output | 5 | Destination register for the current element |
| elemRs1 | output | 5 | Source-1 register for the current element |
| elemRs2 | output | 5 | Source-2 register for the current element |

## Verification
A wrong element counter shows up on the first busy cycle. It appears as an elemIdx out of step or as busy lasting the wrong number of cycles, and done then comes early or late in the same run. A corrupted index register or a wrong vector flag shows up one element after it is loaded, as a register index that drifts from base+i or one that moves when it should hold. A bad table lookup or a bad invert bit shows up on the start cycle through predRegSel. Otherwise it shows up within the first elements as a write-enable pattern that does not match the chosen mask.

// File: rtl/vis_pkg.sv
package vis_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } visStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } visState_t;

endpackage

// File: rtl/vis_pred_table.sv
module vis_pred_table #(
  parameter int ENTRIES = 4,
  parameter int RIDX_W  = 5,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic              wrValid,
  input  logic              wrFp,
  input  logic [RIDX_W-1:0] wrKey,
  input  logic [RIDX_W-1:0] wrVal,
  input  logic              wrInv,
  input  logic [RIDX_W-1:0] lookupKey,
  output logic              hit,
  output logic [RIDX_W-1:0] hitVal,
  output logic              hitInv
);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entFp;
  logic [ENTRIES-1:0] entInv;
  logic [RIDX_W-1:0]  entKey [ENTRIES];
  logic [RIDX_W-1:0]  entVal [ENTRIES];
  logic [ENTRIES-1:0] entMatch;

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
        entFp[e]    <= 1'b0;
        entInv[e]   <= 1'b0;
        entKey[e]   <= '0;
        entVal[e]   <= '0;
      end else if (wrEn && (wrSlot == SLOT_W'(e))) begin
        entValid[e] <= wrValid;
        entFp[e]    <= wrFp;
        entInv[e]   <= wrInv;
        entKey[e]   <= wrKey;
        entVal[e]   <= wrVal;
      end
    end
    // only integer-file entries apply to an integer destination
    assign entMatch[e] = entValid[e] && !entFp[e] && (entKey[e] == lookupKey);
  end

  // lowest slot wins: scan downward so the last assignment is slot 0
  always_comb begin
    hit    = 1'b0;
    hitVal = '0;
    hitInv = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (entMatch[e]) begin
        hit    = 1'b1;
        hitVal = entVal[e];
        hitInv = entInv[e];
      end
    end
  end

endmodule

// File: rtl/vis_ctrl.sv
module vis_ctrl
  import vis_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lenIsZero,
  input  logic       isLast,
  output visStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  visState_t stateQ, stateD;

  always_comb begin
    stateD      = stateQ;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateD      = lenIsZero ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (isLast) stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_RUN);
  assign done = (stateQ == ST_DONE);

endmodule

// File: rtl/vis_dpath.sv
module vis_dpath
  import vis_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5,
  localparam int IDX_W = $clog2(XLEN),
  localparam int LEN_W = $clog2(XLEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  visStrobe_t        strobe,
  input  logic [RIDX_W-1:0] rdIn,
  input  logic [RIDX_W-1:0] rs1In,
  input  logic [RIDX_W-1:0] rs2In,
  input  logic              rdVec,
  input  logic              rs1Vec,
  input  logic              rs2Vec,
  input  logic [LEN_W-1:0]  vlIn,
  input  logic [LEN_W-1:0]  rdLenIn,
  input  logic              maskHit,
  input  logic              maskInv,
  input  logic [XLEN-1:0]   predData,
  output logic              lenIsZero,
  output logic              isLast,
  output logic              maskBit,
  output logic [IDX_W-1:0]  elemIdx,
  output logic [RIDX_W-1:0] elemRd,
  output logic [RIDX_W-1:0] elemRs1,
  output logic [RIDX_W-1:0] elemRs2
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(XLEN);

  logic [LEN_W-1:0]  vlClamp, rdLenClamp, cntD, cntQ;
  logic [XLEN-1:0]   maskD, maskQ;
  logic [IDX_W-1:0]  idxQ;
  logic [RIDX_W-1:0] rdQ, rs1Q, rs2Q;
  logic              rdVecQ, rs1VecQ, rs2VecQ;

  assign vlClamp    = (vlIn > MAX_LEN) ? MAX_LEN : vlIn;
  assign rdLenClamp = (rdLenIn > MAX_LEN) ? MAX_LEN : rdLenIn;
  assign cntD       = (vlClamp < rdLenClamp) ? vlClamp : rdLenClamp;
  assign lenIsZero  = (cntD == '0);

  always_comb begin
    if (!maskHit)     maskD = '1;
    else if (maskInv) maskD = ~predData;
    else              maskD = predData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      maskQ   <= '0;
      idxQ    <= '0;
      rdQ     <= '0;
      rs1Q    <= '0;
      rs2Q    <= '0;
      rdVecQ  <= 1'b0;
      rs1VecQ <= 1'b0;
      rs2VecQ <= 1'b0;
    end else if (strobe.load) begin
      cntQ    <= cntD;
      maskQ   <= maskD;
      idxQ    <= '0;
      rdQ     <= rdIn;
      rs1Q    <= rs1In;
      rs2Q    <= rs2In;
      rdVecQ  <= rdVec;
      rs1VecQ <= rs1Vec;
      rs2VecQ <= rs2Vec;
    end else if (strobe.step) begin
      idxQ <= idxQ + IDX_W'(1);
      rdQ  <= rdQ + RIDX_W'(rdVecQ);
      rs1Q <= rs1Q + RIDX_W'(rs1VecQ);
      rs2Q <= rs2Q + RIDX_W'(rs2VecQ);
    end
  end

  assign isLast  = (LEN_W'(idxQ) == (cntQ - LEN_W'(1)));
  assign maskBit = maskQ[idxQ];
  assign elemIdx = idxQ;
  assign elemRd  = rdQ;
  assign elemRs1 = rs1Q;
  assign elemRs2 = rs2Q;

endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
  import vis_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RIDX_W  = 5,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(XLEN),
  localparam int LEN_W  = $clog2(XLEN + 1),
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWe,
  input  logic [SLOT_W-1:0] tblSlot,
  input  logic              tblValid,
  input  logic              tblFp,
  input  logic [RIDX_W-1:0] tblKey,
  input  logic [RIDX_W-1:0] tblVal,
  input  logic              tblInv,
  input  logic              start,
  input  logic [RIDX_W-1:0] rdIn,
  input  logic [RIDX_W-1:0] rs1In,
  input  logic [RIDX_W-1:0] rs2In,
  input  logic              rdVec,
  input  logic              rs1Vec,
  input  logic              rs2Vec,
  input  logic [LEN_W-1:0]  vlIn,
  input  logic [LEN_W-1:0]  rdLenIn,
  output logic [RIDX_W-1:0] predRegSel,
  input  logic [XLEN-1:0]   predData,
  output logic              busy,
  output logic              done,
  output logic              elemWe,
  output logic [IDX_W-1:0]  elemIdx,
  output logic [RIDX_W-1:0] elemRd,
  output logic [RIDX_W-1:0] elemRs1,
  output logic [RIDX_W-1:0] elemRs2
);

  visStrobe_t strobe;
  logic maskHit, maskInv, lenIsZero, isLast, maskBit;

  vis_pred_table #(.ENTRIES(ENTRIES), .RIDX_W(RIDX_W)) uTable (
    .clk(clk), .rstN(rstN),
    .wrEn(tblWe), .wrSlot(tblSlot), .wrValid(tblValid), .wrFp(tblFp),
    .wrKey(tblKey), .wrVal(tblVal), .wrInv(tblInv),
    .lookupKey(rdIn), .hit(maskHit), .hitVal(predRegSel), .hitInv(maskInv)
  );

  vis_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lenIsZero(lenIsZero),
    .isLast(isLast), .strobe(strobe), .busy(busy), .done(done)
  );

  vis_dpath #(.XLEN(XLEN), .RIDX_W(RIDX_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdIn(rdIn), .rs1In(rs1In), .rs2In(rs2In),
    .rdVec(rdVec), .rs1Vec(rs1Vec), .rs2Vec(rs2Vec),
    .vlIn(vlIn), .rdLenIn(rdLenIn),
    .maskHit(maskHit), .maskInv(maskInv), .predData(predData),
    .lenIsZero(lenIsZero), .isLast(isLast), .maskBit(maskBit),
    .elemIdx(elemIdx), .elemRd(elemRd), .elemRs1(elemRs1), .elemRs2(elemRs2)
  );

  assign elemWe = busy & maskBit;

endmodule

// File: rtl/vis_checker.sv
module vis_checker #(
  parameter int IDX_W  = 5,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              elemWe,
  input logic [IDX_W-1:0]  elemIdx,
  input logic [RIDX_W-1:0] elemRd
);

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    elemWe |-> busy); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (elemIdx == $past(elemIdx) + IDX_W'(1))); // R1

  AST_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (elemIdx == '0)); // R1

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |->
      ((elemRd == $past(elemRd)) || (elemRd == $past(elemRd) + RIDX_W'(1)))); // R3

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R8

  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R9

endmodule

bind vec_issue_seq vis_checker #(.IDX_W(IDX_W), .RIDX_W(RIDX_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .elemWe(elemWe), .elemIdx(elemIdx), .elemRd(elemRd)
);

// File: tb/tb_vec_issue_seq.sv
module tb_vec_issue_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tblWe = 1'b0, tblValid = 1'b0, tblFp = 1'b0, tblInv = 1'b0;
  logic [1:0] tblSlot = '0;
  logic [4:0] tblKey = '0, tblVal = '0;
  logic start = 1'b0;
  logic [4:0] rdIn = '0, rs1In = '0, rs2In = '0;
  logic rdVec = 1'b0, rs1Vec = 1'b0, rs2Vec = 1'b0;
  logic [5:0] vlIn = '0, rdLenIn = '0;
  logic [4:0] predRegSel;
  logic [31:0] predData;
  logic busy, done, elemWe;
  logic [4:0] elemIdx, elemRd, elemRs1, elemRs2;

  int nVec = 0;
  int nBad = 0;

  // model table
  bit       mValid [4];
  bit       mFp    [4];
  bit       mInv   [4];
  int       mKey   [4];
  int       mVal   [4];

  always #5 clk = ~clk;

  function automatic logic [31:0] patt(input logic [4:0] r);
    return (32'h9E37_79B9 * (32'(r) + 32'd1)) ^ (32'hFFFF_FFFF << r);
  endfunction

  // register file model feeding the mask read port
  always_comb predData = patt(predRegSel);

  vec_issue_seq dut (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblSlot(tblSlot),
    .tblValid(tblValid), .tblFp(tblFp), .tblKey(tblKey), .tblVal(tblVal),
    .tblInv(tblInv), .start(start), .rdIn(rdIn), .rs1In(rs1In), .rs2In(rs2In),
    .rdVec(rdVec), .rs1Vec(rs1Vec), .rs2Vec(rs2Vec), .vlIn(vlIn),
    .rdLenIn(rdLenIn), .predRegSel(predRegSel), .predData(predData),
    .busy(busy), .done(done), .elemWe(elemWe), .elemIdx(elemIdx),
    .elemRd(elemRd), .elemRs1(elemRs1), .elemRs2(elemRs2)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeSlot(input int s, input bit v, input bit fp, input int k,
                           input int val, input bit inv);
    @(negedge clk);
    tblWe = 1'b1; tblSlot = 2'(s); tblValid = v; tblFp = fp;
    tblKey = 5'(k); tblVal = 5'(val); tblInv = inv;
    mValid[s] = v; mFp[s] = fp; mKey[s] = k % 32; mVal[s] = val % 32; mInv[s] = inv;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic setTable(input int cfg, input int rd);
    // decoy in slot 3 keyed to a different register
    writeSlot(3, 1, 0, rd ^ 1, 20, 0);
    writeSlot(0, cfg == 1 || cfg == 4, cfg == 3, rd, (cfg == 4) ? 3 : 7, 0);
    writeSlot(1, cfg == 2, 0, rd, 12, 1);
    writeSlot(2, cfg == 4, 0, rd, 9, 1);
  endtask

  task automatic runOp(input int rd, input int r1, input int r2, input bit v0,
                       input bit v1, input bit v2, input int vl, input int rl,
                       input bit poke);
    bit hit = 0; bit inv = 0; int val = 0;
    logic [31:0] mask;
    int cnt, cv, cr;
    for (int s = 3; s >= 0; s--)
      if (mValid[s] && !mFp[s] && mKey[s] == rd) begin hit = 1; inv = mInv[s]; val = mVal[s]; end
    mask = !hit ? 32'hFFFF_FFFF : (inv ? ~patt(5'(val)) : patt(5'(val)));
    cv = (vl > 32) ? 32 : vl;
    cr = (rl > 32) ? 32 : rl;
    cnt = (cv < cr) ? cv : cr;
    @(negedge clk);
    start = 1'b1; rdIn = 5'(rd); rs1In = 5'(r1); rs2In = 5'(r2);
    rdVec = v0; rs1Vec = v1; rs2Vec = v2; vlIn = 6'(vl); rdLenIn = 6'(rl);
    #1;
    if (hit) check(predRegSel == 5'(val), "R4 predRegSel", predRegSel, val);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      check(busy == 1'b1 && done == 1'b0, "R1 busy during run", {busy, done}, 2'b10);
      check(elemIdx == 5'(i), "R1 elemIdx", elemIdx, i);
      check(elemWe == mask[i], "R2/R4/R5/R6/R7 elemWe", elemWe, mask[i]);
      check(elemRd == 5'(rd + (v0 ? i : 0)), "R3 elemRd", elemRd, (rd + (v0 ? i : 0)) % 32);
      check(elemRs1 == 5'(r1 + (v1 ? i : 0)), "R3 elemRs1", elemRs1, (r1 + (v1 ? i : 0)) % 32);
      check(elemRs2 == 5'(r2 + (v2 ? i : 0)), "R3 elemRs2", elemRs2, (r2 + (v2 ? i : 0)) % 32);
      if (poke && i == 0) begin
        // R9: start while busy must be ignored
        start = 1'b1; rdIn = 5'(rd + 5); vlIn = 6'd1; rdVec = ~v0;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b1 && busy == 1'b0 && elemWe == 1'b0, "R8 done pulse",
          {done, busy, elemWe}, 3'b100);
    if (poke) begin
      start = 1'b1; vlIn = 6'd3; rdLenIn = 6'd3; // R9: ignored during done
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && busy == 1'b0, "R8/R9 back to idle", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int vls[8] = '{0, 1, 2, 5, 31, 32, 40, 63};
    int rls[3] = '{32, 3, 63};
    for (int s = 0; s < 4; s++) begin
      mValid[s] = 0; mFp[s] = 0; mInv[s] = 0; mKey[s] = 0; mVal[s] = 0;
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && elemWe == 1'b0, "R10 reset state",
          {busy, done, elemWe}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && elemWe == 1'b0, "R10 idle after reset",
          {busy, done, elemWe}, 3'b000);
    for (int vi = 0; vi < 8; vi++)
      for (int ri = 0; ri < 3; ri++)
        for (int combo = 0; combo < 8; combo++)
          for (int cfg = 0; cfg < 5; cfg++) begin
            int rd = (vi * 11 + combo * 5 + cfg * 3 + ri * 13 + 28) % 32;
            setTable(cfg, rd);
            runOp(rd, (rd + 9) % 32, (rd + 20) % 32, combo[0], combo[1], combo[2],
                  vls[vi], rls[ri], ((combo + cfg) % 3) == 0);
          end
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule